// File: doc/BRIEF.md
# Oscillator Failure Detector with Clock-Source Fallback

This block decides whether a fast main oscillator is still running by comparing it with a slow reference clock. A small counter runs on the main oscillator clock. It is held cleared while the slow clock is low and counts rising edges while the slow clock is high. At every slow-clock falling edge, the slow-clock logic takes a "enough edges seen" flag from the phase that just ended, through a two-flop synchronizer. If a phase produced fewer than `MIN_EDGES` edges, the oscillator has stopped or is running too slowly.

The block reports a failure in three ways: a live status bit, a sticky event bit that is cleared by a status read, and an interrupt that can be masked. When a failure is found, the block takes over the clock-source selects. The main clock source is forced to the internal fast RC oscillator, and that oscillator is switched on. If the master clock was running from a PLL while the crystal fed the main clock, the master clock select is forced to the main clock. The overrides stay in force until software clears them.

All control inputs are taken on the slow-clock falling edge. A pulse on `sr_read` or `ovr_clr` must therefore be held across one falling edge of `clk_slow`.

Top module: `osc_fail_guard`

## Requirements
- R1: While `rst_n` is low, `fail_status`, `fail_event`, `fail_irq`, `ovr_main_rc` and `ovr_mck_main` are 0. The select outputs pass their inputs through unchanged: `main_src_sel` = `mosc_sel_in`, `mck_sel_out` = `mck_sel_in`, `rc_en_out` = `rc_en_in`.
- R2: The detector is active only when `det_en` = 1 and `osc_en` = 1. While it is not active, `fail_status` is 0 and no event is raised, whatever the main clock does. Clearing either enable drops `fail_status` at once.
- R3: After the detector becomes active, `fail_status` stays 0 until the third slow-clock falling edge has passed. This keeps a partial first phase from being judged.
- R4: Suppose a slow-clock high phase ends at falling edge F0 with fewer than `MIN_EDGES` (default 8) rising edges of `clk_main`. This covers both a stopped clock and a clock that is too slow. Then `fail_status` goes to 1 after the next falling edge F1.
- R5: `fail_event` sets at the falling edge after the one at which `fail_status` rose. It stays set until `sr_read` is sampled high at a falling edge. If a failure is present at that same edge, the set wins.
- R6: `fail_irq` is 1 exactly when `fail_event` = 1 and `irq_en` = 1.
- R7: `ovr_main_rc` sets in the same cycle as `fail_event`. While it is set, `main_src_sel` = 0 (encoding: 0 = fast RC, 1 = crystal) and `rc_en_out` = 1.
- R8: A failure may be found while `mosc_sel_in` = 1 and `mck_sel_in` is 2 or 3 (the PLLs; encoding 0 = slow clock, 1 = main clock). In that case `ovr_mck_main` sets one falling edge after `ovr_main_rc`, and `mck_sel_out` is then forced to 1. If `mck_sel_in` is 0 or 1, `mck_sel_out` is left unchanged.
- R9: Both overrides stay set after the oscillator recovers. They clear only when `ovr_clr` is sampled high at a falling edge, and a failure that is still present wins over the clear.
- R10: After a high phase with at least `MIN_EDGES` edges, `fail_status` returns to 0 one falling edge after the edge that ends that phase. `fail_event` and the overrides keep their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_main | input | 1 | Main oscillator clock under watch |
| clk_slow | input | 1 | Slow reference clock; control logic runs on its falling edge |
| rst_n | input | 1 | Asynchronous core reset, active low |
| det_en | input | 1 | Detector enable |
| osc_en | input | 1 | Main oscillator enable; 0 holds the detector off |
| irq_en | input | 1 | Interrupt mask for the failure event |
| mosc_sel_in | input | 1 | Requested main clock source (1 = crystal, 0 = fast RC) |
| mck_sel_in | input | 2 | Requested master clock source (0 slow, 1 main, 2/3 PLL) |
| rc_en_in | input | 1 | Requested fast RC oscillator enable |
| sr_read | input | 1 | Status read strobe; clears the event |
| ovr_clr | input | 1 | Clears both overrides |
| fail_status | output | 1 | Live failure condition |
| fail_event | output | 1 | Sticky failure event |
| fail_irq | output | 1 | Masked interrupt request |
| ovr_main_rc | output | 1 | Main source forced to the fast RC |
| ovr_mck_main | output | 1 | Master clock forced to the main clock |
| main_src_sel | output | 1 | Effective main clock source |
| mck_sel_out | output | 2 | Effective master clock source |
| rc_en_out | output | 1 | Effective fast RC enable |

## Verification
Every result is due at a fixed falling edge of the slow clock, counted from the falling edge that ends the short phase. Status is due one edge later, the event and the RC override two edges later, and the master-clock override three edges later. Recovery clears status one edge after the edge that ends a good phase. The bench changes its inputs and samples its outputs 5 ns after each slow-clock rising edge, midway between two falling edges. It therefore steps through the scenario one slow cycle at a time and checks each output in the exact step where it is due, as well as in the step just before, where the output must still hold its old value.

// File: rtl/osc_fail_guard.sv
module osc_fail_guard #(
  parameter int MIN_EDGES = 8,
  parameter int ARM_EDGES = 3
) (
  input  logic       clk_main,
  input  logic       clk_slow,
  input  logic       rst_n,
  input  logic       det_en,
  input  logic       osc_en,
  input  logic       irq_en,
  input  logic       mosc_sel_in,
  input  logic [1:0] mck_sel_in,
  input  logic       rc_en_in,
  input  logic       sr_read,
  input  logic       ovr_clr,
  output logic       fail_status,
  output logic       fail_event,
  output logic       fail_irq,
  output logic       ovr_main_rc,
  output logic       ovr_mck_main,
  output logic       main_src_sel,
  output logic [1:0] mck_sel_out,
  output logic       rc_en_out
);
  localparam int CW = $clog2(MIN_EDGES + 1);
  localparam int AW = $clog2(ARM_EDGES + 1);

  logic          active, run, reached, armed, pll_pend;
  logic [CW-1:0] edge_cnt;
  logic [AW-1:0] arm_cnt;
  logic [1:0]    sync_q;

  assign active = det_en & osc_en;
  assign run    = clk_slow & active & rst_n;

  always_ff @(posedge clk_main or negedge run)
    if (!run)          edge_cnt <= '0;
    else if (!reached) edge_cnt <= edge_cnt + 1'b1;

  assign reached = (edge_cnt == CW'(MIN_EDGES));

  always_ff @(negedge clk_slow or negedge rst_n)
    if (!rst_n) sync_q <= 2'b11;
    else        sync_q <= {sync_q[0], reached};

  always_ff @(negedge clk_slow or negedge rst_n)
    if (!rst_n)       arm_cnt <= '0;
    else if (!active) arm_cnt <= '0;
    else if (!armed)  arm_cnt <= arm_cnt + 1'b1;

  assign armed       = (arm_cnt == AW'(ARM_EDGES));
  assign fail_status = active & armed & ~sync_q[1];

  always_ff @(negedge clk_slow or negedge rst_n)
    if (!rst_n) begin
      fail_event   <= 1'b0;
      ovr_main_rc  <= 1'b0;
      ovr_mck_main <= 1'b0;
      pll_pend     <= 1'b0;
    end else begin
      pll_pend <= fail_status & mosc_sel_in & mck_sel_in[1];
      if (fail_status)  fail_event <= 1'b1;
      else if (sr_read) fail_event <= 1'b0;
      if (fail_status)  ovr_main_rc <= 1'b1;
      else if (ovr_clr) ovr_main_rc <= 1'b0;
      if (pll_pend)     ovr_mck_main <= 1'b1;
      else if (ovr_clr) ovr_mck_main <= 1'b0;
    end

  assign fail_irq     = fail_event & irq_en;
  assign main_src_sel = ovr_main_rc ? 1'b0 : mosc_sel_in;
  assign rc_en_out    = rc_en_in | ovr_main_rc;
  assign mck_sel_out  = ovr_mck_main ? 2'b01 : mck_sel_in;
endmodule

// File: rtl/osc_fail_guard_chk.sv
module osc_fail_guard_chk (
  input logic       clk_slow,
  input logic       rst_n,
  input logic       det_en,
  input logic       osc_en,
  input logic       irq_en,
  input logic       sr_read,
  input logic       ovr_clr,
  input logic       fail_status,
  input logic       fail_event,
  input logic       fail_irq,
  input logic       ovr_main_rc,
  input logic       ovr_mck_main,
  input logic       main_src_sel,
  input logic       rc_en_out,
  input logic [1:0] mck_sel_out
);
  AST_IDLE_NO_STATUS: assert property (@(negedge clk_slow) disable iff (!rst_n)
    !(det_en && osc_en) |-> !fail_status); // R2
  AST_EVENT_AFTER_STATUS: assert property (@(negedge clk_slow) disable iff (!rst_n)
    $rose(fail_event) |-> $past(fail_status)); // R5
  AST_EVENT_STICKY: assert property (@(negedge clk_slow) disable iff (!rst_n)
    (fail_event && !sr_read) |=> fail_event); // R5
  AST_IRQ_MASKED: assert property (@(negedge clk_slow) disable iff (!rst_n)
    fail_irq |-> (fail_event && irq_en)); // R6
  AST_RC_FORCED: assert property (@(negedge clk_slow) disable iff (!rst_n)
    ovr_main_rc |-> (rc_en_out && !main_src_sel)); // R7
  AST_MCK_AFTER_RC: assert property (@(negedge clk_slow) disable iff (!rst_n)
    $rose(ovr_mck_main) |-> $past(ovr_main_rc)); // R8
  AST_MCK_FORCED: assert property (@(negedge clk_slow) disable iff (!rst_n)
    ovr_mck_main |-> (mck_sel_out == 2'b01)); // R8
  AST_OVR_HELD: assert property (@(negedge clk_slow) disable iff (!rst_n)
    (ovr_main_rc && !ovr_clr) |=> ovr_main_rc); // R9
endmodule

bind osc_fail_guard osc_fail_guard_chk u_chk (
  .clk_slow(clk_slow), .rst_n(rst_n), .det_en(det_en), .osc_en(osc_en),
  .irq_en(irq_en), .sr_read(sr_read), .ovr_clr(ovr_clr),
  .fail_status(fail_status), .fail_event(fail_event), .fail_irq(fail_irq),
  .ovr_main_rc(ovr_main_rc), .ovr_mck_main(ovr_mck_main),
  .main_src_sel(main_src_sel), .rc_en_out(rc_en_out), .mck_sel_out(mck_sel_out)
);

// File: tb/osc_fail_guard_tb.sv
`timescale 1ns/1ps
module osc_fail_guard_tb;
  logic clk = 0, clk_slow = 0, rst_n = 0;
  logic main_on = 1, slow_mode = 0;
  logic [2:0] dc = '0;
  logic det_en = 0, osc_en = 1, irq_en = 0, mosc_sel_in = 1, rc_en_in = 0;
  logic sr_read = 0, ovr_clr = 0;
  logic [1:0] mck_sel_in = 2'd2;
  logic clk_main;
  logic fail_status, fail_event, fail_irq, ovr_main_rc, ovr_mck_main, main_src_sel, rc_en_out;
  logic [1:0] mck_sel_out;
  int errors = 0, checks = 0;
  bit done = 0;

  always #10 clk = ~clk;
  always #320 clk_slow = ~clk_slow;
  always @(posedge clk) dc <= dc + 1'b1;
  assign clk_main = main_on & (slow_mode ? dc[2] : clk);

  osc_fail_guard u_dut (.*);

  task automatic step(int n = 1);
    repeat (n) begin @(posedge clk_slow); #5; end
  endtask

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic t_reset();
    step(2);
    chk("R1 status", fail_status, 0); chk("R1 event", fail_event, 0);
    chk("R1 irq", fail_irq, 0); chk("R1 ovr_rc", ovr_main_rc, 0);
    chk("R1 ovr_mck", ovr_mck_main, 0); chk("R1 main_src", main_src_sel, 1);
    chk("R1 mck_sel", mck_sel_out, 2); chk("R1 rc_en", rc_en_out, 0);
    rst_n = 1;
    step(2);
  endtask

  task automatic t_arm();
    main_on = 0; det_en = 1;
    step(2);
    chk("R3 masked", fail_status, 0);
    step(1);
    chk("R3 armed", fail_status, 1);
    det_en = 0; #1;
    chk("R2 drop", fail_status, 0);
    step(1);
    chk("R2 no event", fail_event, 0);
    main_on = 1;
    step(2);
  endtask

  task automatic t_disabled();
    det_en = 1; osc_en = 0; main_on = 0;
    for (int i = 0; i < 6; i++) begin
      step(1);
      chk("R2 osc off status", fail_status, 0);
    end
    chk("R2 osc off event", fail_event, 0);
    chk("R2 osc off ovr", ovr_main_rc, 0);
    main_on = 1; osc_en = 1;
    step(5);
    chk("R4 healthy", fail_status, 0);
  endtask

  task automatic t_stop_pll();
    irq_en = 1; mck_sel_in = 2; mosc_sel_in = 1;
    main_on = 0;
    step(1);
    chk("R4 not yet", fail_status, 0);
    step(1);
    chk("R4 status", fail_status, 1); chk("R5 not yet", fail_event, 0);
    step(1);
    chk("R5 event", fail_event, 1); chk("R6 irq", fail_irq, 1);
    chk("R7 ovr_rc", ovr_main_rc, 1); chk("R7 main_src", main_src_sel, 0);
    chk("R7 rc_en", rc_en_out, 1); chk("R8 not yet", ovr_mck_main, 0);
    chk("R8 mck before", mck_sel_out, 2);
    step(1);
    chk("R8 ovr_mck", ovr_mck_main, 1); chk("R8 mck forced", mck_sel_out, 1);
    sr_read = 1;
    step(1);
    sr_read = 0;
    chk("R5 set wins", fail_event, 1);
    main_on = 1;
    step(1);
    chk("R10 still failing", fail_status, 1);
    step(1);
    chk("R10 recovered", fail_status, 0); chk("R10 event kept", fail_event, 1);
    chk("R9 ovr kept", ovr_main_rc, 1); chk("R9 mck kept", ovr_mck_main, 1);
    sr_read = 1;
    step(1);
    sr_read = 0;
    chk("R5 cleared", fail_event, 0); chk("R6 irq cleared", fail_irq, 0);
    chk("R9 ovr after read", ovr_main_rc, 1);
    ovr_clr = 1;
    step(1);
    ovr_clr = 0;
    chk("R9 rc cleared", ovr_main_rc, 0); chk("R9 mck cleared", ovr_mck_main, 0);
    chk("R9 main_src back", main_src_sel, 1); chk("R9 mck back", mck_sel_out, 2);
    chk("R9 rc_en back", rc_en_out, 0);
  endtask

  task automatic t_slow_main();
    irq_en = 0; mck_sel_in = 1; slow_mode = 1;
    step(2);
    chk("R4 slow status", fail_status, 1);
    step(1);
    chk("R5 slow event", fail_event, 1); chk("R6 masked", fail_irq, 0);
    chk("R7 slow ovr_rc", ovr_main_rc, 1);
    step(1);
    chk("R8 no pll ovr", ovr_mck_main, 0); chk("R8 mck kept", mck_sel_out, 1);
    irq_en = 1; #1;
    chk("R6 unmask", fail_irq, 1);
    slow_mode = 0;
    step(3);
    chk("R10 slow recovered", fail_status, 0);
    sr_read = 1; ovr_clr = 1;
    step(1);
    sr_read = 0; ovr_clr = 0;
    chk("R5 final clear", fail_event, 0); chk("R9 final clear", ovr_main_rc, 0);
  endtask

  initial begin
    t_reset();
    t_arm();
    t_disabled();
    t_stop_pll();
    t_slow_main();
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #200000;
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule